// File: doc/BRIEF.md
# Multi-Bus Fault Address Capture

This block sits beside three bus decoders: the instruction bus, the data bus and the system bus. Each decoder raises a one-cycle strobe together with the address it could not decode. While capture is enabled, the block latches that address into a register reserved for the bus and raises a sticky per-bus fault flag. Software can then read back which buses have faulted and where.

A captured address is frozen while its flag is set, so the first faulting address on a bus is the one kept. Software releases all three capture slots at once by writing any value to the status register. Access is through a small single-cycle register port. Writes take effect at the clock edge. Reads are combinational on the register index.

Top module: `fault_capture_unit`

## Requirements
- R1: Reset (synchronous, active-low `rst_n`) clears the capture-enable bit, all three fault flags and all three captured-address registers to zero.
- R2: Register index 0 holds the capture-enable bit in bit 0 (written from `cfg_wdata[0]`, upper read bits zero). A fault strobe is ignored while this bit is 0: no flag is set and no address changes.
- R3: Register index 1 is the status register. Bit 0 is the instruction-bus flag, bit 1 the data-bus flag and bit 2 the system-bus flag. A 1 means a fault was captured, and the upper bits read zero.
- R4: With capture enabled, a strobe on a bus whose flag is clear sets that flag and loads the address on that bus at the same clock edge. Both are visible in the next cycle.
- R5: While a bus's flag is set, later strobes on that bus change neither its captured address nor its flag. The address is also kept after the flag is cleared, until the next capture.
- R6: Any write to the status register clears all three flags, whatever the written data (zero included).
- R7: If a status write and an enabled strobe on a bus fall in the same cycle, that bus's flag ends set and its address register takes the new address, even if the flag was already set.
- R8: Strobes on different buses in the same cycle are each captured into their own register. Lane i takes `flt_addr[32*i +: 32]`, with 0 the instruction bus, 1 the data bus and 2 the system bus.
- R9: Clearing the capture-enable bit leaves flags and captured addresses unchanged.
- R10: Indices 2, 3 and 4 read the instruction-bus, data-bus and system-bus captured addresses. Writes to them are ignored, and indices 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_idx` (combinational) |
| flt_strobe | input | 3 | Per-bus fault strobe (bit 0 instruction, 1 data, 2 system) |
| flt_addr | input | 96 | Per-bus faulting address, 32 bits per lane |

## Verification
The properties assume that the strobes and addresses are synchronous to `clk` and hold defined values whenever a strobe is high. They also assume that a status write is signalled only by `cfg_wr` together with index 1, with no other path able to clear a flag. The stimulus drives every input on the falling edge and holds it for a full cycle, so each strobe is seen at exactly one rising edge. Strobes are driven only with known address patterns that differ per lane, which lets a lane mix-up show as a wrong read value.

// File: rtl/fcap_pkg.sv
// Package: shared constants for the fault address capture block.
// Assumes a register index of IDX_W bits that selects enable, status and
// per-bus captured-address registers.
package fcap_pkg;
    localparam int IDX_W         = 3;
    localparam int REG_ENABLE    = 0;
    localparam int REG_STATUS    = 1;
    localparam int REG_ADDR_BASE = 2;

    typedef enum logic [1:0] {
        LANE_INSTR  = 2'd0,
        LANE_DATA   = 2'd1,
        LANE_SYSTEM = 2'd2
    } lane_e;
endpackage

// File: rtl/fcap_lane.sv
// Module: one capture slot (sticky flag plus frozen address) for a single bus.
// Assumes strobe is synchronous and addr_in is valid while strobe is high.
// A new fault beats a simultaneous clear.
module fcap_lane #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              clr_all,
    input  logic              strobe,
    input  logic [WORD_W-1:0] addr_in,
    output logic              flag_q,
    output logic [WORD_W-1:0] addr_q
);
    logic take;

    // Decide whether this cycle's strobe is captured.
    always_comb begin
        take = cap_en && strobe && (!flag_q || clr_all);
    end

    // Update the sticky flag and frozen address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            addr_q <= '0;
        end else if (take) begin
            flag_q <= 1'b1;
            addr_q <= addr_in;
        end else if (clr_all) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/fcap_regif.sv
// Module: register decode for the capture block. Holds the enable bit,
// produces the clear-all pulse on any status write, and muxes read data.
// Assumes single-cycle writes and combinational reads.
module fcap_regif
    import fcap_pkg::*;
#(
    parameter int NUM_BUS = 3,
    parameter int WORD_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_wr,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  logic                      wr_bit0,
    input  logic [NUM_BUS-1:0]        flags,
    input  logic [NUM_BUS*WORD_W-1:0] addr_flat,
    output logic                      cap_en_q,
    output logic                      stat_clr,
    output logic [WORD_W-1:0]         rdata
);
    localparam int LAST_ADDR_IDX = REG_ADDR_BASE + NUM_BUS - 1;

    // Hold the capture-enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_en_q <= 1'b0;
        end else if (cfg_wr && (int'(cfg_idx) == REG_ENABLE)) begin
            cap_en_q <= wr_bit0;
        end
    end

    // Flag a status write of any data.
    always_comb begin
        stat_clr = cfg_wr && (int'(cfg_idx) == REG_STATUS);
    end

    // Select read data by register index.
    always_comb begin
        rdata = '0;
        if (int'(cfg_idx) == REG_ENABLE) begin
            rdata[0] = cap_en_q;
        end else if (int'(cfg_idx) == REG_STATUS) begin
            rdata[NUM_BUS-1:0] = flags;
        end else if (int'(cfg_idx) <= LAST_ADDR_IDX) begin
            for (int i = 0; i < NUM_BUS; i++) begin
                if (int'(cfg_idx) == REG_ADDR_BASE + i) begin
                    rdata = addr_flat[i*WORD_W +: WORD_W];
                end
            end
        end
    end
endmodule

// File: rtl/fault_capture_unit.sv
// Module: top of the multi-bus fault address capture block. One capture
// lane per bus plus a register interface. Assumes all inputs are
// synchronous to clk; lane i reads flt_addr[WORD_W*i +: WORD_W].
module fault_capture_unit
    import fcap_pkg::*;
#(
    parameter int NUM_BUS = 3,
    parameter int WORD_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_wr,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  logic [WORD_W-1:0]         cfg_wdata,
    output logic [WORD_W-1:0]         cfg_rdata,
    input  logic [NUM_BUS-1:0]        flt_strobe,
    input  logic [NUM_BUS*WORD_W-1:0] flt_addr
);
    logic                      cap_en;
    logic                      stat_clr;
    logic [NUM_BUS-1:0]        flag_vec;
    logic [NUM_BUS*WORD_W-1:0] addr_flat;
    logic                      unused_wdata;

    // Only bit 0 of write data is stored.
    assign unused_wdata = ^cfg_wdata[WORD_W-1:1];

    fcap_regif #(
        .NUM_BUS(NUM_BUS),
        .WORD_W (WORD_W)
    ) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_idx  (cfg_idx),
        .wr_bit0  (cfg_wdata[0]),
        .flags    (flag_vec),
        .addr_flat(addr_flat),
        .cap_en_q (cap_en),
        .stat_clr (stat_clr),
        .rdata    (cfg_rdata)
    );

    for (genvar g = 0; g < NUM_BUS; g++) begin : g_lane
        fcap_lane #(
            .WORD_W(WORD_W)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .cap_en (cap_en),
            .clr_all(stat_clr),
            .strobe (flt_strobe[g]),
            .addr_in(flt_addr[g*WORD_W +: WORD_W]),
            .flag_q (flag_vec[g]),
            .addr_q (addr_flat[g*WORD_W +: WORD_W])
        );
    end
endmodule

// File: rtl/fcap_checker.sv
// Module: assertion checker for fault_capture_unit, attached by bind.
// Assumes strobes and addresses are synchronous and defined when used.
module fcap_checker
    import fcap_pkg::*;
#(
    parameter int NUM_BUS = 3,
    parameter int WORD_W  = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_wr,
    input logic [IDX_W-1:0]          cfg_idx,
    input logic [NUM_BUS-1:0]        flt_strobe,
    input logic [NUM_BUS*WORD_W-1:0] flt_addr,
    input logic                      cap_en,
    input logic [NUM_BUS-1:0]        flags,
    input logic [NUM_BUS*WORD_W-1:0] addr_flat
);
    logic stat_wr;
    assign stat_wr = cfg_wr && (int'(cfg_idx) == REG_STATUS);

    AST_NO_RISE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> ((flags & ~$past(flags)) == '0)); // R2

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && (flt_strobe == '0)) |=> (flags == '0)); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((flags & $past(flags)) == $past(flags))); // R9

    for (genvar g = 0; g < NUM_BUS; g++) begin : g_chk
        AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_en && flt_strobe[g] && !flags[g]) |=>
            (flags[g] && addr_flat[g*WORD_W +: WORD_W] == $past(flt_addr[g*WORD_W +: WORD_W]))); // R4

        AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[g] && !stat_wr) |=>
            (flags[g] && $stable(addr_flat[g*WORD_W +: WORD_W]))); // R5

        AST_FAULT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_en && flt_strobe[g] && stat_wr) |=>
            (flags[g] && addr_flat[g*WORD_W +: WORD_W] == $past(flt_addr[g*WORD_W +: WORD_W]))); // R7
    end
endmodule

bind fault_capture_unit fcap_checker #(
    .NUM_BUS(NUM_BUS),
    .WORD_W (WORD_W)
) u_fcap_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_idx   (cfg_idx),
    .flt_strobe(flt_strobe),
    .flt_addr  (flt_addr),
    .cap_en    (cap_en),
    .flags     (flag_vec),
    .addr_flat (addr_flat)
);

// File: tb/fault_capture_unit_test.sv
`timescale 1ns/1ps
// Bench: table-driven walk of fault_capture_unit, then directed reset tests.
module fault_capture_unit_test;
    localparam int NB = 3;
    localparam int W  = 32;

    typedef struct packed {
        logic [3:0]  req;
        logic        wr;
        logic [2:0]  widx;
        logic [31:0] wdata;
        logic [2:0]  stb;
        logic [31:0] abase;
        logic [2:0]  ridx;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{4'd2,  1'b0, 3'd0, 32'h0,        3'b111, 32'h1000, 3'd1, 32'h0},    // R2 strobes ignored while disabled
        '{4'd2,  1'b0, 3'd0, 32'h0,        3'b000, 32'h0,    3'd2, 32'h0},    // R2 no address loaded
        '{4'd2,  1'b1, 3'd0, 32'h1,        3'b000, 32'h0,    3'd0, 32'h1},    // R2 enable readback
        '{4'd3,  1'b0, 3'd0, 32'h0,        3'b001, 32'h1000, 3'd1, 32'h1},    // R3 instr flag in bit 0
        '{4'd4,  1'b0, 3'd0, 32'h0,        3'b000, 32'h0,    3'd2, 32'h1000}, // R4 address loaded
        '{4'd5,  1'b0, 3'd0, 32'h0,        3'b001, 32'h2000, 3'd2, 32'h1000}, // R5 later fault does not overwrite
        '{4'd8,  1'b0, 3'd0, 32'h0,        3'b110, 32'h3000, 3'd1, 32'h7},    // R8 R3 two buses in one cycle
        '{4'd8,  1'b0, 3'd0, 32'h0,        3'b000, 32'h0,    3'd3, 32'h3010}, // R8 data lane
        '{4'd8,  1'b0, 3'd0, 32'h0,        3'b000, 32'h0,    3'd4, 32'h3020}, // R8 system lane
        '{4'd6,  1'b1, 3'd1, 32'h0,        3'b000, 32'h0,    3'd1, 32'h0},    // R6 write of zero clears all
        '{4'd5,  1'b0, 3'd0, 32'h0,        3'b000, 32'h0,    3'd2, 32'h1000}, // R5 address kept after clear
        '{4'd4,  1'b0, 3'd0, 32'h0,        3'b010, 32'h4000, 3'd3, 32'h4010}, // R4 recapture after clear
        '{4'd7,  1'b1, 3'd1, 32'hFFFFFFFF, 3'b010, 32'h5000, 3'd1, 32'h2},    // R7 fault beats clear
        '{4'd7,  1'b0, 3'd0, 32'h0,        3'b000, 32'h0,    3'd3, 32'h5010}, // R7 new address taken
        '{4'd9,  1'b1, 3'd0, 32'h0,        3'b000, 32'h0,    3'd1, 32'h2},    // R9 disable keeps flags
        '{4'd9,  1'b0, 3'd0, 32'h0,        3'b000, 32'h0,    3'd3, 32'h5010}, // R9 disable keeps address
        '{4'd2,  1'b0, 3'd0, 32'h0,        3'b111, 32'h6000, 3'd1, 32'h2},    // R2 disabled again, ignored
        '{4'd10, 1'b1, 3'd3, 32'hDEADBEEF, 3'b000, 32'h0,    3'd3, 32'h5010}, // R10 address write ignored
        '{4'd10, 1'b0, 3'd0, 32'h0,        3'b000, 32'h0,    3'd5, 32'h0}     // R10 unused index reads zero
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [W-1:0]  cfg_wdata = '0;
    logic [W-1:0]  cfg_rdata;
    logic [NB-1:0] flt_strobe = '0;
    logic [NB*W-1:0] flt_addr = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fault_capture_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .flt_strobe(flt_strobe),
        .flt_addr  (flt_addr)
    );

    // Compare one read against its expected value.
    task automatic check(input int req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    // Read a register combinationally between edges.
    task automatic read_chk(input int req, input logic [2:0] idx, input logic [W-1:0] exp);
        cfg_idx = idx;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    // Drive one cycle of stimulus, then read after the capturing edge.
    task automatic step(input vec_t v);
        @(negedge clk);
        cfg_wr     = v.wr;
        cfg_idx    = v.widx;
        cfg_wdata  = v.wdata;
        flt_strobe = v.stb;
        for (int i = 0; i < NB; i++) flt_addr[i*W +: W] = v.abase + 32'(i * 16);
        @(negedge clk);
        cfg_wr     = 1'b0;
        flt_strobe = '0;
        read_chk(int'(v.req), v.ridx, v.exp);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                // R1: state after power-on reset
                rst_n = 1'b1;
                for (int i = 0; i < 5; i++) read_chk(1, 3'(i), '0);

                for (int k = 0; k < NV; k++) step(VECS[k]);

                // R1: reset in the middle of operation
                step('{4'd2, 1'b1, 3'd0, 32'h1, 3'b000, 32'h0, 3'd0, 32'h1});
                step('{4'd8, 1'b0, 3'd0, 32'h0, 3'b111, 32'hA000, 3'd1, 32'h7});
                @(negedge clk);
                rst_n = 1'b0;
                @(negedge clk);
                rst_n = 1'b1;
                for (int i = 0; i < 5; i++) read_chk(1, 3'(i), '0);
                done = 1'b1;
            end
            begin
                repeat (200000) @(posedge clk);
                if (!done) begin
                    checks++;
                    errors++;
                    $display("FAIL watchdog: actual timeout expected completion");
                end
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule